// File: doc/BRIEF.md
# Per-Sample Rounding and Output Window Stage

This block sits behind the accumulator of a multi-tap filter. Each clock it takes a 32-bit accumulated result, adds a programmable 32-bit rounding constant to it, and passes a contiguous 16-bit slice of the 32-bit sum to the output. Sixteen rounding constants and sixteen 5-bit window positions are held in two small register files.

A 4-bit index input, presented together with each sample, picks both the rounding constant and the window position for that sample. The index may differ on every clock, so two or more interleaved data streams can share the stage with their own rounding and scaling. Loading zero into a rounding constant and selecting it passes the result through without rounding. Both register files are loaded through one write port with a one-bit target flag.

The datapath has two registered stages: the addition, then the window extraction. A sample presented at one rising edge appears on the output after the second rising edge.

Top module: `rnd_win`

## Requirements
- R1: While `rst_ni` is low, `data_o` is 0 and every rounding constant and window position is 0. After reset, before any write, the output is the low 16 bits of each sample.
- R2: The sum is `data_i` plus rounding constant number `sel_i`, taken modulo 2^32. A constant of zero leaves the sample unrounded.
- R3: For window position s, `data_o` is bits [s+15:s] of the 32-bit sum.
- R4: A stored window position above 16 acts as 16, which selects sum bits [31:16].
- R5: `sel_i` may change every cycle. The value presented with a sample chooses both that sample's rounding constant and its window position, whatever index later samples use.
- R6: A sample presented before rising edge k appears on `data_o` after rising edge k+1 and holds until the next edge.
- R7: A write lands at the next rising edge. A sample whose `sel_i` equals the index being written in the same cycle uses the old contents, and the next sample uses the new contents. Entries that are not written keep their values.
- R8: With `wr_en_i` high, `wr_tgt_i` = 0 writes all 32 bits of `wr_data_i` into rounding constant `wr_addr_i`, and `wr_tgt_i` = 1 writes `wr_data_i[4:0]` into window position `wr_addr_i`, ignoring the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 32 | Accumulated filter result for this cycle |
| sel_i | input | 4 | Index of the rounding constant and window position for this sample |
| wr_en_i | input | 1 | Register-file write strobe |
| wr_tgt_i | input | 1 | Write target: 0 rounding constant, 1 window position |
| wr_addr_i | input | 4 | Entry index to write |
| wr_data_i | input | 32 | Write data (window writes use bits 4:0) |
| data_o | output | 16 | Rounded, windowed result |

## Verification
A register-file write and a sample that reads the same entry can fall in the same cycle. The outcome depends on whether the read returns the old or the new entry. The bench provokes this by writing a rounding constant and a window position at the very index that `sel_i` carries in that cycle and in the next one. Its behavioural model applies writes only after it has computed the current sample's expected value, so the sample in the writing cycle is judged against the old entry and the following sample against the new one. Every output cycle is compared with the model, including samples that pass through while the register files are being loaded.

// File: rtl/rw_pkg.sv
package rw_pkg;
  typedef enum logic {
    WR_ROUND  = 1'b0,
    WR_WINDOW = 1'b1
  } wr_tgt_e;
endpackage

// File: rtl/rw_regfile.sv
module rw_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [DEPTH-1:0][W-1:0] mem_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '0;
      else if (we_i && (waddr_i == AW'(i)))        mem_q[i] <= wdata_i;
    end
  end

  // read returns pre-write contents in the writing cycle
  assign rdata_o = mem_q[raddr_i];

  // R7
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem_q));
endmodule

// File: rtl/rw_add_stage.sv
module rw_add_stage #(
  parameter int W         = 32,
  parameter int SH_W      = 5,
  parameter int MAX_SHIFT = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    data_i,
  input  logic [W-1:0]    rnd_i,
  input  logic [SH_W-1:0] pos_i,
  output logic [W-1:0]    sum_o,
  output logic [SH_W-1:0] shift_o
);
  localparam logic [SH_W-1:0] SH_MAX = SH_W'(MAX_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o   <= '0;
      shift_o <= '0;
    end else begin
      sum_o   <= data_i + rnd_i;
      shift_o <= (pos_i > SH_MAX) ? SH_MAX : pos_i;
    end
  end

  // R4
  shift_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o <= SH_MAX);
endmodule

// File: rtl/rw_window_stage.sv
module rw_window_stage #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 16,
  parameter int SH_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IN_W-1:0]  sum_i,
  input  logic [SH_W-1:0]  shift_i,
  output logic [OUT_W-1:0] data_o
);
  localparam int NPOS = IN_W - OUT_W + 1;

  logic [OUT_W-1:0] cand [NPOS];

  for (genvar s = 0; s < NPOS; s++) begin : g_pos
    assign cand[s] = sum_i[s +: OUT_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= cand[shift_i];
  end
endmodule

// File: rtl/rnd_win.sv
module rnd_win #(
  parameter int DATA_W = 32,
  parameter int OUT_W  = 16,
  parameter int NREG   = 16,
  parameter int AW     = $clog2(NREG),
  parameter int MAX_SHIFT = DATA_W - OUT_W,
  parameter int SH_W   = $clog2(MAX_SHIFT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic [AW-1:0]     sel_i,
  input  logic              wr_en_i,
  input  logic              wr_tgt_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [OUT_W-1:0]  data_o
);
  import rw_pkg::*;

  logic              we_rnd, we_pos;
  logic [DATA_W-1:0] rnd_rd;
  logic [SH_W-1:0]   pos_rd;
  logic [DATA_W-1:0] sum_w;
  logic [SH_W-1:0]   shift_w;
  logic              warm_q;

  assign we_rnd = wr_en_i && (wr_tgt_e'(wr_tgt_i) == WR_ROUND);
  assign we_pos = wr_en_i && (wr_tgt_e'(wr_tgt_i) == WR_WINDOW);

  rw_regfile #(.W(DATA_W), .DEPTH(NREG), .AW(AW)) u_rnd_rf (
    .clk_i, .rst_ni,
    .we_i(we_rnd), .waddr_i(wr_addr_i), .wdata_i(wr_data_i),
    .raddr_i(sel_i), .rdata_o(rnd_rd)
  );

  rw_regfile #(.W(SH_W), .DEPTH(NREG), .AW(AW)) u_pos_rf (
    .clk_i, .rst_ni,
    .we_i(we_pos), .waddr_i(wr_addr_i), .wdata_i(wr_data_i[SH_W-1:0]),
    .raddr_i(sel_i), .rdata_o(pos_rd)
  );

  rw_add_stage #(.W(DATA_W), .SH_W(SH_W), .MAX_SHIFT(MAX_SHIFT)) u_add (
    .clk_i, .rst_ni,
    .data_i, .rnd_i(rnd_rd), .pos_i(pos_rd),
    .sum_o(sum_w), .shift_o(shift_w)
  );

  rw_window_stage #(.IN_W(DATA_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_win (
    .clk_i, .rst_ni,
    .sum_i(sum_w), .shift_i(shift_w), .data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= 1'b0;
    else         warm_q <= 1'b1;
  end

  // R2
  sum_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q |-> sum_w == DATA_W'($past(data_i) + $past(rnd_rd)));

  // R3
  out_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q |-> data_o == OUT_W'($past(sum_w) >> $past(shift_w)));

  // R1
  rst_out_chk: assert property (@(posedge clk_i)
    !rst_ni |-> data_o == '0);
endmodule

// File: tb/tb_rnd_win.sv
`timescale 1ns/1ps
module tb_rnd_win;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] data_i = '0;
  logic [3:0]  sel_i = '0;
  logic        wr_en_i = 1'b0;
  logic        wr_tgt_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [15:0] data_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] rnd_m [16];
  logic [4:0]  pos_m [16];
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  rnd_win dut (
    .clk_i(clk), .rst_ni, .data_i, .sel_i, .wr_en_i, .wr_tgt_i,
    .wr_addr_i, .wr_data_i, .data_o
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [31:0] d, input logic [3:0] s);
    logic [31:0] sum;
    int sh;
    sum = d + rnd_m[s];
    sh  = (pos_m[s] > 5'd16) ? 16 : int'(pos_m[s]);
    return 16'((sum >> sh) & 32'hFFFF);
  endfunction

  // called at a falling edge; ends at the next falling edge
  task automatic step(input logic [31:0] d, input logic [3:0] s, input logic we,
                      input logic tgt, input logic [3:0] wa, input logic [31:0] wd,
                      input string tag);
    if (exp_q.size() >= 2) check(data_o, exp_q.pop_front(), tag_q.pop_front());
    data_i = d; sel_i = s; wr_en_i = we; wr_tgt_i = tgt; wr_addr_i = wa; wr_data_i = wd;
    exp_q.push_back(model(d, s));
    tag_q.push_back(tag);
    if (we) begin
      if (tgt) pos_m[wa] = wd[4:0];
      else     rnd_m[wa] = wd;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input logic [31:0] d, input logic [3:0] s, input string tag);
    step(d, s, 1'b0, 1'b0, 4'd0, 32'd0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin rnd_m[i] = '0; pos_m[i] = '0; end
    data_i = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check(data_o, 16'h0000, "R1 output during reset");
    @(negedge clk);
    rst_ni = 1'b1;
    exp_q.push_back(16'h0); tag_q.push_back("R1 first cycle after reset");
    exp_q.push_back(16'h0); tag_q.push_back("R1 second cycle after reset");

    // zero registers: pass low half
    for (int i = 0; i < 6; i++) idle($urandom(), 4'(i * 5), "R1 unwritten registers");

    // program round constants (entry 0 stays zero) with live traffic
    for (int i = 1; i < 16; i++)
      step($urandom(), 4'(15 - i), 1'b1, 1'b0, 4'(i), $urandom(), "R8 round write traffic");
    // window positions, upper data bits set to show they are dropped
    for (int i = 0; i < 16; i++) begin
      logic [4:0] p;
      case (i)
        0: p = 5'd0;  1: p = 5'd16; 2: p = 5'd17; 3: p = 5'd31;
        default: p = 5'(i);
      endcase
      step($urandom(), 4'(i), 1'b1, 1'b1, 4'(i), 32'hFFFF_FFE0 | 32'(p),
           "R8 window write traffic");
    end

    // zero round constant with window 0: unrounded low half
    idle(32'h1234_5678, 4'd0, "R2 zero constant passes sample");
    // clamp
    idle(32'hABCD_0123, 4'd2, "R4 position 17 clamps to 16");
    idle(32'h0F0F_F0F0, 4'd3, "R4 position 31 clamps to 16");
    idle(32'h8000_0001, 4'd1, "R3 position 16 top half");

    // wrap
    step(32'h0, 4'd5, 1'b1, 1'b0, 4'd5, 32'h0000_0010, "R2 set wrap constant");
    idle(32'hFFFF_FFF8, 4'd5, "R2 sum wraps modulo 2^32");
    idle(32'hFFFF_FFFF, 4'd5, "R2 sum wraps modulo 2^32");

    // per-cycle index changes
    for (int i = 0; i < 300; i++) idle($urandom(), 4'($urandom()), "R5 per-sample index");
    for (int i = 0; i < 32; i++) idle(32'h0001_0000 << (i % 16), 4'(i % 16), "R3 R5 index sweep");

    // same-cycle write and read
    step(32'h7777_1111, 4'd6, 1'b1, 1'b0, 4'd6, 32'h0000_8000, "R7 read old round in write cycle");
    idle(32'h7777_1111, 4'd6, "R7 new round next cycle");
    step(32'h00F0_0F00, 4'd7, 1'b1, 1'b1, 4'd7, 32'd4, "R7 read old window in write cycle");
    idle(32'h00F0_0F00, 4'd7, "R7 new window next cycle");
    idle(32'h00F0_0F00, 4'd8, "R7 unwritten entry unchanged");

    // latency: isolated impulse among zeros on entry 0
    idle(32'h0, 4'd0, "R6 before impulse");
    idle(32'h0000_A5A5, 4'd0, "R6 impulse");
    idle(32'h0, 4'd0, "R6 after impulse");
    idle(32'h0, 4'd0, "R6 after impulse");

    for (int i = 0; i < 3; i++) idle(32'h0, 4'd0, "R6 drain");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule